// File: doc/BRIEF.md
# Sector lock and protection register guard

This block sits beside the command decoder of a dual-plane flash array. It keeps one volatile lock bit for each of 39 sectors and decides whether each decoded program or erase request may proceed. For a chip-wide erase it returns the set of sectors that may actually be erased, which leaves out every locked sector. It also owns a 128-bit protection register. The lower 64 bits are a fixed factory number, supplied as a parameter. The upper 64 bits are a user block that can be programmed and then sealed once.

A 20-bit word address is mapped to a sector index and a plane using a top-heavy layout. The bottom 31 sectors hold 32K words each. The top 32K words are split into eight 4K-word sectors. Every sector starting at 0xC0000 or above belongs to plane A.

When the identification flag is raised, read requests return identification data instead of array data. A read can return a sector's lock state, a protection-register word, or the lock state of the user block. Every accepted command gets a response on the following clock.

Top module: `sector_guard`

## Requirements
- R1: Each command's response reports a sector index and a plane flag (1 = plane A). Addresses below 0xF8000 map to index address/32768, which gives 0 to 30. Addresses from 0xF8000 map to 31 + (address-0xF8000)/4096, which gives 31 to 38. The plane flag is 1 exactly when the address is at least 0xC0000.
- R2: A synchronous reset clears every sector lock bit. After reset, programs and erases to any sector are granted.
- R3: A sector lock command (op 4) is always granted. It sets the lock bit of the addressed sector only. No command other than reset clears a lock bit.
- R4: A word program (op 1) or a sector erase (op 2) to a locked sector is denied, and its erase mask is zero. To an unlocked sector it is granted, and the erase mask has only the bit of that sector set.
- R5: A chip erase (op 3) is always granted. Its erase mask has bit i set exactly when sector i is unlocked.
- R6: An identification read (op 0 with the identification flag at 1) at offset 2 within a sector returns that sector's lock bit on data bit 0 (1 = locked) and zeros on the other bits. A read with the flag at 0 returns data 0.
- R7: An identification read at 0x81 to 0x88, with address bits 19 to 8 all zero, returns protection word (address-0x81). Words 0 to 3 are the 16-bit slices of the factory parameter, lowest slice first. Words 4 to 7 are the user block, which powers up as 0xFFFF. Identification reads at other addresses return 0, apart from the cases in R6 and R11.
- R8: A protection program (op 5) to a factory word (0x81 to 0x84) is denied and leaves the word unchanged.
- R9: A protection program to a user word (0x85 to 0x88) while the user block is unlocked is granted. It stores the AND of the old word and the written data.
- R10: A protection lock (op 6) at address 0x80 with data bit 1 equal to 0 is granted and seals the user block permanently. With data bit 1 equal to 1 it is denied and has no effect. Once the block is sealed, protection programs are denied and leave the words unchanged.
- R11: An identification read at 0x80 returns data 0x0002 while the user block is unsealed, and 0x0000 once it is sealed.
- R12: The response (rsp_valid, grant, deny, erase_mask, sector, plane, data) is registered and appears one clock after cmd_valid. With no command, every response output is 0. Reads (op 0) and op 7 respond with neither grant nor deny.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | A command is presented this cycle |
| cmd_op | input | 3 | 0 read, 1 program, 2 sector erase, 3 chip erase, 4 sector lock, 5 protection program, 6 protection lock, 7 none |
| cmd_addr | input | 20 | Word address |
| cmd_data | input | 16 | Write data |
| id_mode | input | 1 | Identification mode flag |
| rsp_valid | output | 1 | Response present |
| rsp_grant | output | 1 | Request permitted |
| rsp_deny | output | 1 | Request refused |
| rsp_erase_mask | output | 39 | Sectors that the request may modify |
| rsp_sector | output | 6 | Sector index of the address |
| rsp_plane_a | output | 1 | Address lies in plane A |
| rsp_rdata | output | 16 | Identification read data |

## Verification
A lock bit held in the wrong state shows up on the very next program, erase or chip-erase response to that sector, as a flipped grant/deny or a wrong mask bit. It also shows on any identification read at offset 2 of that sector, one clock after the read. A corrupted user word or a wrong seal state is visible one clock after a read at 0x85 to 0x88 or at 0x80. The AND rule can only be seen by writing the same word twice. The bench compares every response field on every clock, so a mapping error at a sector edge is caught in the cycle it first occurs.

// File: rtl/sg_pkg.sv
package sg_pkg;
  typedef enum logic [2:0] {
    OP_READ   = 3'd0,
    OP_PROG   = 3'd1,
    OP_SERASE = 3'd2,
    OP_CERASE = 3'd3,
    OP_SLOCK  = 3'd4,
    OP_PPROG  = 3'd5,
    OP_PLOCK  = 3'd6,
    OP_NONE   = 3'd7
  } sg_op_e;
endpackage

// File: rtl/sg_sector_map.sv
module sg_sector_map #(
  parameter int ADDR_W       = 20,
  parameter int BIG_SECT_W   = 15,
  parameter int SMALL_SECT_W = 12,
  parameter int NUM_BIG      = 31,
  parameter int SECT_IDX_W   = 6,
  parameter int LOCK_OFS     = 2,
  parameter logic [ADDR_W-1:0] PLANE_A_BASE = 20'hC0000
) (
  input  logic [ADDR_W-1:0]     addr,
  output logic [SECT_IDX_W-1:0] sect,
  output logic                  plane_a,
  output logic                  at_lock_ofs
);
  localparam int TOP_W = ADDR_W - BIG_SECT_W;
  localparam int SUB_W = BIG_SECT_W - SMALL_SECT_W;

  logic in_small;

  always_comb begin
    in_small = (addr[ADDR_W-1:BIG_SECT_W] == TOP_W'(NUM_BIG));
    if (in_small)
      sect = SECT_IDX_W'(NUM_BIG) + SECT_IDX_W'(addr[BIG_SECT_W-1 -: SUB_W]);
    else
      sect = SECT_IDX_W'(addr[ADDR_W-1:BIG_SECT_W]);
    if (in_small)
      at_lock_ofs = (addr[SMALL_SECT_W-1:0] == SMALL_SECT_W'(LOCK_OFS));
    else
      at_lock_ofs = (addr[BIG_SECT_W-1:0] == BIG_SECT_W'(LOCK_OFS));
    plane_a = (addr >= PLANE_A_BASE);
  end
endmodule

// File: rtl/sg_lock_bank.sv
module sg_lock_bank #(
  parameter int NUM_SECT   = 39,
  parameter int SECT_IDX_W = 6
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  set_en,
  input  logic [SECT_IDX_W-1:0] set_idx,
  output logic [NUM_SECT-1:0]   lock_o
);
  for (genvar i = 0; i < NUM_SECT; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst)
        lock_o[i] <= 1'b0;
      else if (set_en && (set_idx == SECT_IDX_W'(i)))
        lock_o[i] <= 1'b1;
    end
  end
endmodule

// File: rtl/sg_prot_reg.sv
module sg_prot_reg #(
  parameter int ADDR_W     = 20,
  parameter int DATA_W     = 16,
  parameter int PREG_WORDS = 8,
  parameter logic [7:0] PREG_BASE = 8'h80,
  parameter int SEAL_BIT   = 1,
  parameter logic [DATA_W*PREG_WORDS/2-1:0] FACTORY_ID = 64'h0123_4567_89AB_CDEF
) (
  input  logic              clk,
  input  logic              prog_req,
  input  logic              seal_req,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic              word_hit,
  output logic              stat_hit,
  output logic [DATA_W-1:0] word_data,
  output logic              prog_ok,
  output logic              seal_ok,
  output logic              sealed
);
  localparam int HALF  = PREG_WORDS / 2;
  localparam int IDX_W = $clog2(PREG_WORDS);

  logic [DATA_W-1:0] user_mem [HALF] = '{default: '1};
  logic              sealed_q = 1'b0;
  logic [7:0]        rel;
  logic              upper_zero;
  logic [IDX_W-2:0]  sub_idx;
  logic [DATA_W-1:0] fac_word;

  always_comb begin
    upper_zero = (addr[ADDR_W-1:8] == '0);
    rel        = addr[7:0] - (PREG_BASE + 8'd1);
    word_hit   = upper_zero && (rel < 8'(PREG_WORDS));
    stat_hit   = upper_zero && (addr[7:0] == PREG_BASE);
    sub_idx    = rel[IDX_W-2:0];
    fac_word   = FACTORY_ID[DATA_W*int'(sub_idx) +: DATA_W];
    word_data  = rel[IDX_W-1] ? user_mem[sub_idx] : fac_word;
    prog_ok    = prog_req && word_hit && rel[IDX_W-1] && !sealed_q;
    seal_ok    = seal_req && stat_hit && !wdata[SEAL_BIT];
    sealed     = sealed_q;
  end

  always_ff @(posedge clk) begin
    if (prog_ok)
      user_mem[sub_idx] <= user_mem[sub_idx] & wdata;
    if (seal_ok)
      sealed_q <= 1'b1;
  end
endmodule

// File: rtl/sector_guard.sv
module sector_guard
  import sg_pkg::*;
#(
  parameter int ADDR_W       = 20,
  parameter int DATA_W       = 16,
  parameter int BIG_SECT_W   = 15,
  parameter int SMALL_SECT_W = 12,
  parameter int NUM_BIG      = 31,
  parameter int NUM_SMALL    = 8,
  parameter int PREG_WORDS   = 8,
  parameter logic [DATA_W*PREG_WORDS/2-1:0] FACTORY_ID = 64'h0123_4567_89AB_CDEF
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  cmd_valid,
  input  logic [2:0]            cmd_op,
  input  logic [ADDR_W-1:0]     cmd_addr,
  input  logic [DATA_W-1:0]     cmd_data,
  input  logic                  id_mode,
  output logic                  rsp_valid,
  output logic                  rsp_grant,
  output logic                  rsp_deny,
  output logic [NUM_BIG+NUM_SMALL-1:0] rsp_erase_mask,
  output logic [$clog2(NUM_BIG+NUM_SMALL)-1:0] rsp_sector,
  output logic                  rsp_plane_a,
  output logic [DATA_W-1:0]     rsp_rdata
);
  localparam int NUM_SECT   = NUM_BIG + NUM_SMALL;
  localparam int SECT_IDX_W = $clog2(NUM_SECT);
  localparam int SEAL_BIT   = 1;

  sg_op_e                op;
  logic [SECT_IDX_W-1:0] sect;
  logic                  plane_a, at_lock_ofs;
  logic [NUM_SECT-1:0]   lock_q;
  logic                  word_hit, stat_hit, prog_ok, seal_ok, ulock_q;
  logic [DATA_W-1:0]     word_data;
  logic                  grant_n, deny_n;
  logic [NUM_SECT-1:0]   mask_n;
  logic [DATA_W-1:0]     rdata_n;

  assign op = sg_op_e'(cmd_op);

  sg_sector_map #(
    .ADDR_W(ADDR_W), .BIG_SECT_W(BIG_SECT_W), .SMALL_SECT_W(SMALL_SECT_W),
    .NUM_BIG(NUM_BIG), .SECT_IDX_W(SECT_IDX_W)
  ) u_map (
    .addr(cmd_addr), .sect(sect), .plane_a(plane_a), .at_lock_ofs(at_lock_ofs)
  );

  sg_lock_bank #(.NUM_SECT(NUM_SECT), .SECT_IDX_W(SECT_IDX_W)) u_locks (
    .clk(clk), .rst(rst),
    .set_en(cmd_valid && (op == OP_SLOCK)),
    .set_idx(sect), .lock_o(lock_q)
  );

  sg_prot_reg #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PREG_WORDS(PREG_WORDS),
    .SEAL_BIT(SEAL_BIT), .FACTORY_ID(FACTORY_ID)
  ) u_preg (
    .clk(clk),
    .prog_req(cmd_valid && !rst && (op == OP_PPROG)),
    .seal_req(cmd_valid && !rst && (op == OP_PLOCK)),
    .addr(cmd_addr), .wdata(cmd_data),
    .word_hit(word_hit), .stat_hit(stat_hit), .word_data(word_data),
    .prog_ok(prog_ok), .seal_ok(seal_ok), .sealed(ulock_q)
  );

  always_comb begin
    grant_n = 1'b0;
    deny_n  = 1'b0;
    mask_n  = '0;
    rdata_n = '0;
    case (op)
      OP_READ: begin
        if (id_mode) begin
          if (word_hit)
            rdata_n = word_data;
          else if (stat_hit)
            rdata_n = DATA_W'(!ulock_q) << SEAL_BIT;
          else if (at_lock_ofs)
            rdata_n = DATA_W'(lock_q[sect]);
        end
      end
      OP_PROG, OP_SERASE: begin
        if (lock_q[sect]) begin
          deny_n = 1'b1;
        end else begin
          grant_n = 1'b1;
          mask_n  = NUM_SECT'(1) << sect;
        end
      end
      OP_CERASE: begin
        grant_n = 1'b1;
        mask_n  = ~lock_q;
      end
      OP_SLOCK: grant_n = 1'b1;
      OP_PPROG: begin
        grant_n = prog_ok;
        deny_n  = !prog_ok;
      end
      OP_PLOCK: begin
        grant_n = seal_ok;
        deny_n  = !seal_ok;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst || !cmd_valid) begin
      rsp_valid      <= 1'b0;
      rsp_grant      <= 1'b0;
      rsp_deny       <= 1'b0;
      rsp_erase_mask <= '0;
      rsp_sector     <= '0;
      rsp_plane_a    <= 1'b0;
      rsp_rdata      <= '0;
    end else begin
      rsp_valid      <= 1'b1;
      rsp_grant      <= grant_n;
      rsp_deny       <= deny_n;
      rsp_erase_mask <= mask_n;
      rsp_sector     <= sect;
      rsp_plane_a    <= plane_a;
      rsp_rdata      <= rdata_n;
    end
  end
endmodule

// File: rtl/sector_guard_chk.sv
module sector_guard_chk #(
  parameter int NUM_SECT = 39
) (
  input logic                clk,
  input logic                rst,
  input logic                cmd_valid,
  input logic [2:0]          cmd_op,
  input logic                rsp_valid,
  input logic                rsp_grant,
  input logic                rsp_deny,
  input logic [NUM_SECT-1:0] rsp_erase_mask,
  input logic [NUM_SECT-1:0] lock_vec,
  input logic                ulock
);
  AST_RSP_FOLLOWS_CMD: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |=> rsp_valid); // R12

  AST_VERDICT_NEEDS_RSP: assert property (@(posedge clk) disable iff (rst)
    (rsp_grant || rsp_deny) |-> (rsp_valid && !(rsp_grant && rsp_deny))); // R12

  AST_DENY_NO_MASK: assert property (@(posedge clk) disable iff (rst)
    rsp_deny |-> (rsp_erase_mask == '0)); // R4

  AST_SINGLE_SECTOR_MASK: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !$past(rst) && ($past(cmd_op) inside {3'd1, 3'd2})) |-> $onehot0(rsp_erase_mask)); // R4

  AST_CHIP_SKIPS_LOCKED: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !$past(rst) && ($past(cmd_op) == 3'd3)) |-> ((rsp_erase_mask & lock_vec) == '0)); // R5

  AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> ((lock_vec & $past(lock_vec)) == $past(lock_vec))); // R3

  AST_SEAL_STICKY: assert property (@(posedge clk) disable iff (rst)
    $past(ulock) |-> ulock); // R10
endmodule

bind sector_guard sector_guard_chk #(.NUM_SECT(NUM_SECT)) u_chk (
  .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
  .rsp_valid(rsp_valid), .rsp_grant(rsp_grant), .rsp_deny(rsp_deny),
  .rsp_erase_mask(rsp_erase_mask), .lock_vec(lock_q), .ulock(ulock_q)
);

// File: tb/sector_guard_bench.sv
module sector_guard_bench;
  localparam logic [63:0] FACT = 64'h0123_4567_89AB_CDEF;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmd_valid = 1'b0;
  logic [2:0]  cmd_op = 3'd7;
  logic [19:0] cmd_addr = '0;
  logic [15:0] cmd_data = '0;
  logic        id_mode = 1'b0;
  logic        rsp_valid, rsp_grant, rsp_deny, rsp_plane_a;
  logic [38:0] rsp_erase_mask;
  logic [5:0]  rsp_sector;
  logic [15:0] rsp_rdata;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  bit          m_lock [39];
  logic [15:0] m_user [4] = '{default: 16'hFFFF};
  bit          m_seal = 0;

  always #2.5 clk = ~clk;

  sector_guard #(.FACTORY_ID(FACT)) u_sector_guard (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_addr(cmd_addr), .cmd_data(cmd_data), .id_mode(id_mode),
    .rsp_valid(rsp_valid), .rsp_grant(rsp_grant), .rsp_deny(rsp_deny),
    .rsp_erase_mask(rsp_erase_mask), .rsp_sector(rsp_sector),
    .rsp_plane_a(rsp_plane_a), .rsp_rdata(rsp_rdata)
  );

  task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic int sect_of(int a);
    return (a < 'hF8000) ? a / 32768 : 31 + (a - 'hF8000) / 4096;
  endfunction

  function automatic int ofs_of(int a);
    return (a < 'hF8000) ? a % 32768 : a % 4096;
  endfunction

  task automatic step(string req, int op, int a, logic [15:0] d, bit id);
    int s = sect_of(a);
    logic        e_g = 0, e_d = 0;
    logic [38:0] e_m = '0;
    logic [15:0] e_r = '0;
    cmd_valid = 1'b1; cmd_op = op[2:0]; cmd_addr = a[19:0];
    cmd_data = d; id_mode = id;
    case (op)
      0: if (id) begin
        if (a >= 'h81 && a <= 'h88) begin
          int k = a - 'h81;
          e_r = (k < 4) ? FACT[16*k +: 16] : m_user[k-4];
        end else if (a == 'h80) e_r = m_seal ? 16'h0 : 16'h2;
        else if (ofs_of(a) == 2) e_r = {15'b0, m_lock[s]};
      end
      1, 2: if (m_lock[s]) e_d = 1; else begin e_g = 1; e_m[s] = 1'b1; end
      3: begin
        e_g = 1;
        for (int i = 0; i < 39; i++) e_m[i] = !m_lock[i];
      end
      4: begin e_g = 1; m_lock[s] = 1; end
      5: if (a >= 'h85 && a <= 'h88 && !m_seal) begin
        e_g = 1; m_user[a-'h85] = m_user[a-'h85] & d;
      end else e_d = 1;
      6: if (a == 'h80 && !d[1]) begin e_g = 1; m_seal = 1; end else e_d = 1;
      default: ;
    endcase
    @(negedge clk);
    chk(req, "valid", 64'(rsp_valid), 64'd1);
    chk(req, "grant", 64'(rsp_grant), 64'(e_g));
    chk(req, "deny", 64'(rsp_deny), 64'(e_d));
    chk(req, "mask", 64'(rsp_erase_mask), 64'(e_m));
    chk(req, "sector", 64'(rsp_sector), 64'(s));
    chk(req, "plane", 64'(rsp_plane_a), 64'(a >= 'hC0000));
    chk(req, "rdata", 64'(rsp_rdata), 64'(e_r));
  endtask

  task automatic idle(string req);
    cmd_valid = 1'b0; cmd_op = 3'd7;
    @(negedge clk);
    chk(req, "idle valid", 64'(rsp_valid), 64'd0);
    chk(req, "idle grant/deny", 64'({rsp_grant, rsp_deny}), 64'd0);
    chk(req, "idle rdata", 64'(rsp_rdata), 64'd0);
  endtask

  task automatic do_reset();
    rst = 1'b1; cmd_valid = 1'b0;
    repeat (2) begin
      @(negedge clk);
      chk("R2", "valid in reset", 64'(rsp_valid), 64'd0);
    end
    for (int i = 0; i < 39; i++) m_lock[i] = 0;
    rst = 1'b0;
  endtask

  task automatic finish_sim();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_sim();
    end
  end

  initial begin
    @(negedge clk);
    do_reset();
    idle("R12");
    // R2 / R6: nothing locked after reset
    step("R6", 0, 'h00002, 0, 1);
    step("R6", 0, 'hF0002, 0, 1);
    step("R6", 0, 'hF8002, 0, 1);
    step("R6", 0, 'hFF002, 0, 1);
    // R1: sector and plane boundaries
    step("R1", 1, 'h00000, 0, 0);
    step("R1", 1, 'h7FFFF, 0, 0);
    step("R1", 1, 'hBFFFF, 0, 0);
    step("R1", 1, 'hC0000, 0, 0);
    step("R1", 2, 'hF7FFF, 0, 0);
    step("R1", 2, 'hF8000, 0, 0);
    step("R1", 2, 'hFFFFF, 0, 0);
    // R3: lockdown of two sectors
    step("R3", 4, 'h2ABCD, 0, 0);
    step("R3", 4, 'hFA123, 0, 0);
    step("R3", 4, 'hFA001, 0, 0);
    // R4: gating
    step("R4", 1, 'h28000, 16'h1234, 0);
    step("R4", 1, 'h30000, 16'h1234, 0);
    step("R4", 2, 'hFA000, 0, 0);
    step("R4", 2, 'hFB000, 0, 0);
    step("R4", 2, 'h2FFFF, 0, 0);
    // R5: chip erase skips locked
    step("R5", 3, 'h00000, 0, 0);
    // R6: lock readback
    step("R6", 0, 'h28002, 0, 1);
    step("R6", 0, 'h28003, 0, 1);
    step("R6", 0, 'hFA002, 0, 1);
    step("R3", 0, 'h30002, 0, 1);
    step("R6", 0, 'h28002, 0, 0);
    // R7: protection register reads
    for (int a = 'h81; a <= 'h88; a++) step("R7", 0, a, 0, 1);
    step("R7", 0, 'h10081, 0, 1);
    step("R7", 0, 'h89, 0, 1);
    // R8: factory words read-only
    step("R8", 5, 'h81, 16'h0000, 0);
    step("R8", 0, 'h81, 0, 1);
    step("R8", 5, 'h10085, 16'h0000, 0);
    // R9: AND on user program
    step("R9", 5, 'h85, 16'hF0F0, 0);
    step("R9", 5, 'h85, 16'h3C3C, 0);
    step("R9", 0, 'h85, 0, 1);
    step("R9", 5, 'h88, 16'hA5A5, 0);
    step("R9", 0, 'h88, 0, 1);
    // R11 / R10: seal
    step("R11", 0, 'h80, 0, 1);
    step("R10", 6, 'h80, 16'h0002, 0);
    step("R11", 0, 'h80, 0, 1);
    step("R10", 6, 'h81, 16'h0000, 0);
    step("R10", 6, 'h80, 16'hFFFD, 0);
    step("R11", 0, 'h80, 0, 1);
    step("R10", 5, 'h86, 16'h0000, 0);
    step("R10", 0, 'h86, 0, 1);
    step("R12", 7, 'h12345, 0, 0);
    idle("R12");
    // R2: reset clears locks
    do_reset();
    step("R2", 0, 'h28002, 0, 1);
    step("R2", 1, 'h28000, 0, 0);
    step("R2", 3, 'h00000, 0, 0);
    step("R10", 0, 'h80, 0, 1);
    idle("R12");
    done = 1;
    finish_sim();
  end
endmodule